// File: doc/BRIEF.md
# SHA-1 Message Schedule Generator

This block turns one 512-bit message block into the eighty 32-bit schedule words consumed by an iterative SHA-1 compression round, one word per step. The first sixteen words are the block's own words; every later word is formed on the fly. Each new word is the XOR of four earlier schedule words, rotated left by one bit. Only a sliding window of sixteen words is held, not the full expanded schedule.

The round controller loads a block with a one-cycle strobe, then raises a step enable whenever its round consumes the presented word. The block presents the current word together with its round index. After the last word has been consumed it raises a one-cycle completion pulse. A new load may arrive at any time, and it abandons whatever block is in progress.

Top module: `sha1_sched_gen`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `valid_o`, `done_o`, `idx_o` and `w_o` are all zero.
- R2: A cycle with `load_i` high makes `valid_o` high, `idx_o` zero and `w_o` equal to word 0 in the following cycle. Word k of the block is `block_i[511-32k -: 32]`, so word 0 sits in the most significant bits.
- R3: For indices 0 to 15 the presented word is word k of the loaded block, in ascending order.
- R4: For indices 16 to 79 the presented word t is the XOR of words t-3, t-8, t-14 and t-16, rotated left by one bit.
- R5: A cycle with `valid_o` and `step_i` high and `load_i` low advances `idx_o` by one and presents the next word in the following cycle. Without `step_i`, `idx_o` and `w_o` hold.
- R6: A step accepted at index 79 clears `valid_o` and raises `done_o` for exactly one cycle, both in the following cycle. Afterwards `idx_o` is zero.
- R7: A load restarts at index 0 with the new block even when the previous block is unfinished. A load takes priority over a step in the same cycle.
- R8: While `valid_o` is low, `step_i` has no effect and `w_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Block-load strobe |
| block_i | input | 512 | Message block, word 0 in the top bits |
| step_i | input | 1 | Step enable from the round controller |
| w_o | output | 32 | Current schedule word |
| idx_o | output | 7 | Round index of `w_o` |
| valid_o | output | 1 | A schedule word is presented |
| done_o | output | 1 | One-cycle pulse after word 79 is consumed |

## Verification
Every result is due exactly one clock edge after the cycle that caused it. A load shows word 0 one cycle later, and each accepted step shows the next word and index one cycle later. The completion pulse and the drop of `valid_o` come one cycle after the step at index 79. The bench drives its inputs on the falling edge and updates a behavioural model on the rising edge, from the full eighty-word schedule it computes for each loaded block. It compares all four outputs on every falling edge, so an early or late change shows up in the very cycle it happens. The runs cover continuous stepping, random gaps between steps, a reload in the middle of a block with a simultaneous step, and steps while idle.

// File: rtl/sha1_sched_pkg.sv
// Shared types and helpers for the SHA-1 schedule generator.
// Assumes 32-bit words throughout.
package sha1_sched_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // Rotate a word left by one bit position.
    function automatic word_t rotl1(input word_t x);
        return {x[WORD_W-2:0], x[WORD_W-1]};
    endfunction
endpackage

// File: rtl/sha1_sched_window.sv
// Sixteen-word sliding window of schedule words.
// Position 0 holds the word currently presented, position N_WORDS-1 the newest.
// A load fills the window from the block (word 0 in the top bits). An advance
// drops position 0 and appends the next expanded word at the top.
// Assumes load and advance are never both acted upon (load wins).
module sha1_sched_window
    import sha1_sched_pkg::*;
#(
    parameter int N_WORDS = 16,
    parameter int TAP_A   = 13,
    parameter int TAP_B   = 8,
    parameter int TAP_C   = 2,
    parameter int TAP_D   = 0,
    localparam int BLK_W  = N_WORDS * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [BLK_W-1:0] block_i,
    input  logic             adv_i,
    output word_t            head_o
);
    word_t win_q [N_WORDS];
    word_t next_word;

    // Form the next expanded word from the four tap positions.
    always_comb begin
        next_word = rotl1(win_q[TAP_A] ^ win_q[TAP_B] ^ win_q[TAP_C] ^ win_q[TAP_D]);
    end

    // Per-slot storage: load from the block, or shift toward position 0.
    for (genvar k = 0; k < N_WORDS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_q[k] <= '0;
            end else if (load_i) begin
                win_q[k] <= block_i[(N_WORDS-1-k)*WORD_W +: WORD_W];
            end else if (adv_i) begin
                if (k == N_WORDS-1) win_q[k] <= next_word;
                else                win_q[k] <= win_q[(k+1) % N_WORDS];
            end
        end
    end

    assign head_o = win_q[0];
endmodule

// File: rtl/sha1_sched_ctrl.sv
// Round index and activity control for the schedule generator.
// Tracks whether a block is in progress, counts accepted steps and pulses
// done for one cycle after the last step. A load restarts unconditionally.
module sha1_sched_ctrl #(
    parameter int N_STEPS = 80,
    localparam int IDX_W  = $clog2(N_STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    output logic             adv_o,
    output logic             active_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             done_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_STEPS - 1);

    logic at_last;

    // A step is accepted only while active and not overridden by a load.
    always_comb begin
        adv_o   = step_i && active_o && !load_i;
        at_last = (idx_o == LAST_IDX);
    end

    // Index, activity flag and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            idx_o    <= '0;
            done_o   <= 1'b0;
        end else if (load_i) begin
            active_o <= 1'b1;
            idx_o    <= '0;
            done_o   <= 1'b0;
        end else if (adv_o) begin
            if (at_last) begin
                active_o <= 1'b0;
                idx_o    <= '0;
                done_o   <= 1'b1;
            end else begin
                idx_o    <= idx_o + 1'b1;
                done_o   <= 1'b0;
            end
        end else begin
            done_o <= 1'b0;
        end
    end
endmodule

// File: rtl/sha1_sched_gen.sv
// SHA-1 message schedule generator, top level.
// Presents schedule words W0..W(N_STEPS-1) one per accepted step after a
// block load. Assumes the round controller consumes w_o in the cycle it
// raises step_i. Output word is forced to zero while idle.
module sha1_sched_gen
    import sha1_sched_pkg::*;
#(
    parameter int N_WORDS = 16,
    parameter int N_STEPS = 80,
    localparam int IDX_W  = $clog2(N_STEPS),
    localparam int BLK_W  = N_WORDS * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [BLK_W-1:0]   block_i,
    input  logic               step_i,
    output logic [WORD_W-1:0]  w_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               valid_o,
    output logic               done_o
);
    logic  adv;
    logic  active;
    word_t head;

    sha1_sched_ctrl #(.N_STEPS(N_STEPS)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .step_i   (step_i),
        .adv_o    (adv),
        .active_o (active),
        .idx_o    (idx_o),
        .done_o   (done_o)
    );

    sha1_sched_window #(
        .N_WORDS (N_WORDS),
        .TAP_A   (N_WORDS - 3),
        .TAP_B   (N_WORDS - 8),
        .TAP_C   (N_WORDS - 14),
        .TAP_D   (0)
    ) window_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .block_i (block_i),
        .adv_i   (adv),
        .head_o  (head)
    );

    // Gate the word with the activity flag.
    always_comb begin
        valid_o = active;
        w_o     = active ? head : '0;
    end
endmodule

// File: rtl/sha1_sched_gen_chk.sv
// Protocol checker for sha1_sched_gen, attached by bind.
// Checks timing of load, step, hold and completion at the top-level ports.
module sha1_sched_gen_chk #(
    parameter int N_STEPS = 80,
    localparam int IDX_W  = $clog2(N_STEPS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic             step_i,
    input logic [31:0]      w_o,
    input logic [IDX_W-1:0] idx_o,
    input logic             valid_o,
    input logic             done_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_STEPS - 1);

    p_load_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (valid_o && idx_o == '0 && !done_o));

    p_step_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && step_i && !load_i && idx_o != LAST) |=> (valid_o && idx_o == $past(idx_o) + 1'b1));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !step_i && !load_i) |=> ($stable(w_o) && $stable(idx_o) && valid_o));

    p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && step_i && !load_i && idx_o == LAST) |=> (done_o && !valid_o && idx_o == '0));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (w_o == '0 && idx_o == '0));

    p_idle_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !load_i) |=> !valid_o);
endmodule

bind sha1_sched_gen sha1_sched_gen_chk #(.N_STEPS(N_STEPS)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .step_i  (step_i),
    .w_o     (w_o),
    .idx_o   (idx_o),
    .valid_o (valid_o),
    .done_o  (done_o)
);

// File: tb/sha1_sched_gen_tb_top.sv
// Bench for sha1_sched_gen: behavioural reference model compared every cycle.
module sha1_sched_gen_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [511:0] block_i = '0;
    logic         step_i = 1'b0;
    logic [31:0]  w_o;
    logic [6:0]   idx_o;
    logic         valid_o;
    logic         done_o;

    int compared = 0;
    int mismatched = 0;
    string tag = "R1";

    // Reference model state.
    logic [31:0] sched [80];
    bit          m_act = 1'b0;
    int          m_idx = 0;
    bit          m_done = 1'b0;

    always #2.5 clk = ~clk;

    sha1_sched_gen dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .block_i(block_i),
        .step_i(step_i), .w_o(w_o), .idx_o(idx_o), .valid_o(valid_o), .done_o(done_o)
    );

    // Expand a block into its full 80-word schedule (R3, R4).
    task automatic expand(input logic [511:0] b);
        for (int t = 0; t < 80; t++) begin
            if (t < 16) sched[t] = b[511 - 32*t -: 32];
            else begin
                logic [31:0] x;
                x = sched[t-3] ^ sched[t-8] ^ sched[t-14] ^ sched[t-16];
                sched[t] = {x[30:0], x[31]};
            end
        end
    endtask

    // Model update on each rising edge from the stable inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_idx = 0; m_done = 0;
        end else if (load_i) begin
            expand(block_i);
            m_act = 1; m_idx = 0; m_done = 0;
        end else if (step_i && m_act) begin
            if (m_idx == 79) begin m_act = 0; m_idx = 0; m_done = 1; end
            else begin m_idx++; m_done = 0; end
        end else m_done = 0;
    end

    // Compare all outputs against the model.
    task automatic compare();
        logic [31:0] ew;
        ew = m_act ? sched[m_idx] : 32'h0;
        compared++;
        if (valid_o !== m_act || idx_o !== 7'(m_idx) || w_o !== ew || done_o !== m_done) begin
            mismatched++;
            $display("FAIL %s: valid=%0b idx=%0d w=%08h done=%0b expected valid=%0b idx=%0d w=%08h done=%0b",
                     tag, valid_o, idx_o, w_o, done_o, m_act, m_idx, ew, m_done);
        end
    endtask

    // One cycle: check at the falling edge, then drive the next inputs.
    task automatic tick(input bit ld, input logic [511:0] b, input bit st);
        @(negedge clk);
        compare();
        load_i = ld; block_i = b; step_i = st;
    endtask

    function automatic logic [511:0] rand_block();
        logic [511:0] r;
        for (int k = 0; k < 16; k++) r[32*k +: 32] = $urandom;
        return r;
    endfunction

    localparam logic [511:0] ABC = {32'h61626380, {14{32'h0}}, 32'h00000018};

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [511:0] blk;
        tag = "R1";
        repeat (3) tick(0, '0, 0);
        @(negedge clk); rst_n = 1'b1;
        tick(0, '0, 0);
        // R8: steps while idle are ignored.
        tag = "R8";
        repeat (4) tick(0, '0, 1);
        tick(0, '0, 0);
        // R2/R3: load the abc block, then step the first sixteen words.
        tag = "R2";
        tick(1, ABC, 0);
        tick(0, '0, 0);
        tag = "R3";
        for (int i = 0; i < 16; i++) tick(0, '0, 1);
        tick(0, '0, 0);
        // R4: explicit first expanded word of the abc block.
        compared++;
        if (w_o !== 32'hC2C4C700 || idx_o !== 7'd16) begin
            mismatched++;
            $display("FAIL R4: w=%08h idx=%0d expected w=C2C4C700 idx=16", w_o, idx_o);
        end
        tag = "R4";
        for (int i = 16; i < 80; i++) tick(0, '0, 1);
        // R6: completion pulse and idle afterwards.
        tag = "R6";
        repeat (4) tick(0, '0, 0);
        // R5: random block with random step gaps.
        tag = "R5";
        tick(1, rand_block(), 0);
        for (int i = 0; i < 300; i++) tick(0, '0, ($urandom % 3) != 0);
        // R7: reload mid-block with a simultaneous step.
        tag = "R7";
        tick(1, rand_block(), 0);
        for (int i = 0; i < 30; i++) tick(0, '0, 1);
        blk = rand_block();
        tick(1, blk, 1);
        tick(0, '0, 0);
        for (int i = 0; i < 85; i++) tick(0, '0, 1);
        tag = "R6";
        repeat (3) tick(0, '0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule